// File: doc/BRIEF.md
# Serial Sample Word Formatter

This block turns parallel converter samples into a serial bit stream on a single data line, one bit per cycle of a fast bit clock. A one-cycle strobe presents a sample. The block sends it as a word whose length can be set to two bits shorter than the sample, equal to it, or two or four bits longer. Alongside the data it drives a frame marker that outlines each word, a data-clock enable, and a one-hot select that tells the downstream phase generator where to place the data clock relative to the data transitions.

Four configuration inputs shape each word: the word length, the bit order, an inversion of every data slot, and the data-clock phase. The block samples all four when a word starts and holds them until the word ends, so every word goes out with one consistent set of settings. A strobe that arrives while a word is in flight is held and sent straight after it, with no idle slot in between.

Top module: `adc_serial_formatter`

## Requirements
- R1: After reset `ser_dat`, `frame` and `dclk_en` are 0 and `dclk_phase` is 6'b000010 (the 90-degree position). Nothing is sent until the first strobe.
- R2: `cfg_len` codes 0, 1, 2 and 3 give words of W-2, W, W+2 and W+4 bit slots, where W is the sample width (8, 10, 12 and 14 by default). The first slot appears in the cycle after the strobe's clock edge, and `dclk_en` is high for exactly the slots of the word.
- R3: With `cfg_lsb_first`=0 the sample goes out from bit W-1 downward. The W-2 length sends bits W-1 down to 2 and drops the two lowest bits.
- R4: The W+2 length ends with two zero slots after the sample, and the W+4 length ends with four. The zero slots sit at the tail of the word in both bit orders.
- R5: With `cfg_lsb_first`=1 the sample bits go out from the lowest sent bit upward: bit 0 to W-1, or bit 2 to W-1 for the W-2 length.
- R6: With `cfg_invert`=1 every slot of the word is inverted, stuffed zeros included. The line stays 0 while no word is being sent.
- R7: `frame` is high for the first half (length/2) of a word's slots and low for the rest, so each word starts on a rising edge of `frame`.
- R8: `cfg_phase` codes 0 to 5 select the one-hot bit k of `dclk_phase`, meaning a data-clock phase of 30+60k degrees. Codes 6 and 7 select the 90-degree default, bit 1.
- R9: Length, order, inversion and phase are captured when a word starts. A change during a word does not alter that word.
- R10: A strobe during a word is held, and the held sample starts in the cycle right after the word's last slot. A later strobe before that point replaces the held sample.
- R11: A strobe on the clock edge that ends a word's last slot starts the next word in the following cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial slot per cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | One-cycle strobe marking a valid sample |
| smp_dat | input | SMP_W (10) | Parallel sample |
| cfg_len | input | 2 | Word length code |
| cfg_lsb_first | input | 1 | 1 sends the lowest sample bit first |
| cfg_invert | input | 1 | 1 inverts every data slot |
| cfg_phase | input | 3 | Data-clock phase code |
| ser_dat | output | 1 | Serial data bit |
| frame | output | 1 | Frame marker, high in the first half of each word |
| dclk_en | output | 1 | High while a word slot is on the line |
| dclk_phase | output | 6 | One-hot data-clock phase position of the current or last word |

## Verification
The bench builds the block with the default 10-bit sample, so the short setting drops two bits and the two long settings stuff two and four zeros. Every length code therefore exercises a different slice-and-pad rule, in both bit orders and with and without inversion. Word lengths of 8 to 14 slots keep words short enough for strobes to land mid-word, on the last slot and twice within one word. That brings the holding, replacement and gapless-start rules within reach of both directed and random traffic.

// File: rtl/adc_serial_formatter.sv
module adc_serial_formatter #(
  parameter int SMP_W = 10,
  parameter int PH_N  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_stb,
  input  logic [SMP_W-1:0]         smp_dat,
  input  logic [1:0]               cfg_len,
  input  logic                     cfg_lsb_first,
  input  logic                     cfg_invert,
  input  logic [$clog2(PH_N)-1:0]  cfg_phase,
  output logic                     ser_dat,
  output logic                     frame,
  output logic                     dclk_en,
  output logic [PH_N-1:0]          dclk_phase
);
  localparam int MAXW   = SMP_W + 4;
  localparam int CW     = $clog2(MAXW + 1);
  localparam int PHW    = $clog2(PH_N);
  localparam int DEF_PH = 1;

  logic [SMP_W-1:0] word_q, pend_dat;
  logic             pend, active;
  logic [CW-1:0]    cnt, len_q;
  logic             lsb_q, inv_q;
  logic [PH_N-1:0]  ph_q;
  logic             last, start;
  logic [CW-1:0]    nbits, shamt;
  logic [SMP_W-1:0] shv;
  logic             dbit;

  function automatic logic [PH_N-1:0] ph_decode(input logic [PHW-1:0] c);
    if (int'(c) < PH_N) return PH_N'(1) << c;
    return PH_N'(1) << DEF_PH;
  endfunction

  assign last  = active && (cnt == len_q - 1'b1);
  assign start = (!active || last) && (smp_stb || pend);
  assign nbits = (len_q < CW'(SMP_W)) ? len_q : CW'(SMP_W);

  always_comb begin
    shamt = lsb_q ? (CW'(SMP_W) - nbits + cnt) : (CW'(SMP_W - 1) - cnt);
    shv   = word_q >> shamt;
    dbit  = (cnt < nbits) ? shv[0] : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      pend_dat <= '0;
      pend     <= 1'b0;
      active   <= 1'b0;
      cnt      <= '0;
      len_q    <= CW'(SMP_W);
      lsb_q    <= 1'b0;
      inv_q    <= 1'b0;
      ph_q     <= PH_N'(1) << DEF_PH;
    end else begin
      if (start) begin
        word_q <= smp_stb ? smp_dat : pend_dat;
        pend   <= 1'b0;
        active <= 1'b1;
        cnt    <= '0;
        len_q  <= CW'(SMP_W - 2 + 2 * int'(cfg_len));
        lsb_q  <= cfg_lsb_first;
        inv_q  <= cfg_invert;
        ph_q   <= ph_decode(cfg_phase);
      end else begin
        if (smp_stb) begin
          pend     <= 1'b1;
          pend_dat <= smp_dat;
        end
        if (last) active <= 1'b0;
        else if (active) cnt <= cnt + 1'b1;
      end
    end
  end

  assign ser_dat    = active && (dbit ^ inv_q);
  assign frame      = active && (cnt < (len_q >> 1));
  assign dclk_en    = active;
  assign dclk_phase = ph_q;

  assert_slot_in_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt < len_q);

  assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> ($stable(len_q) && $stable(lsb_q) && $stable(inv_q) && $stable(ph_q)));

  assert_phase_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(dclk_phase));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dclk_en |-> (!ser_dat && !frame));

  assert_frame_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(frame) && dclk_en) |-> cnt == (len_q >> 1));

  assert_no_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (last && (pend || smp_stb)) |=> (dclk_en && frame && cnt == '0));
endmodule

// File: tb/test_adc_serial_formatter.sv
module test_adc_serial_formatter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic [W-1:0] smp_dat = '0;
  logic [1:0] cfg_len = 2'd1;
  logic cfg_lsb_first = 1'b0, cfg_invert = 1'b0;
  logic [2:0] cfg_phase = 3'd1;
  logic ser_dat, frame, dclk_en;
  logic [5:0] dclk_phase;

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R1";

  bit q_bit[$];
  bit q_frm[$];
  bit m_pend = 1'b0;
  logic [W-1:0] m_pend_dat = '0;
  int m_ph = 1;

  adc_serial_formatter #(.SMP_W(W), .PH_N(6)) i_adc_serial_formatter (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_dat(smp_dat),
    .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first), .cfg_invert(cfg_invert),
    .cfg_phase(cfg_phase), .ser_dat(ser_dat), .frame(frame),
    .dclk_en(dclk_en), .dclk_phase(dclk_phase));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic push_word(input logic [W-1:0] s);
    int len, k;
    bit b;
    len = W - 2 + 2 * int'(cfg_len);
    k = (len < W) ? len : W;
    for (int i = 0; i < len; i++) begin
      if (i < k) b = cfg_lsb_first ? s[i + (W - k)] : s[W - 1 - i];
      else b = 1'b0;
      q_bit.push_back(b ^ cfg_invert);
      q_frm.push_back(i < len / 2);
    end
    m_ph = (cfg_phase < 3'd6) ? int'(cfg_phase) : 1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q_bit.delete(); q_frm.delete(); m_pend = 1'b0; m_ph = 1;
    end else begin
      if (q_bit.size() > 0) begin
        void'(q_bit.pop_front()); void'(q_frm.pop_front());
      end
      if (q_bit.size() == 0 && (smp_stb || m_pend)) begin
        push_word(smp_stb ? smp_dat : m_pend_dat);
        m_pend = 1'b0;
      end else if (smp_stb) begin
        m_pend = 1'b1; m_pend_dat = smp_dat;
      end
    end
  end

  always @(negedge clk) begin
    logic e_en, e_dat, e_frm;
    logic [5:0] e_ph;
    e_en  = q_bit.size() > 0;
    e_dat = e_en ? q_bit[0] : 1'b0;
    e_frm = e_en ? q_frm[0] : 1'b0;
    e_ph  = 6'b1 << m_ph;
    checks++;
    if ({ser_dat, frame, dclk_en, dclk_phase} !== {e_dat, e_frm, e_en, e_ph}) begin
      fails++;
      $display("FAIL %s t=%0t dat/frm/en/ph actual %b/%b/%b/%b expected %b/%b/%b/%b",
               cur_req, $time, ser_dat, frame, dclk_en, dclk_phase, e_dat, e_frm, e_en, e_ph);
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cycles > 100000) begin
    checks++; fails++;
    $display("FAIL watchdog expired: actual %0d cycles expected under 100000", cycles);
    finish_run();
  end

  task automatic strobe(input logic [W-1:0] s);
    @(negedge clk); smp_stb = 1'b1; smp_dat = s;
    @(negedge clk); smp_stb = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q_bit.size() > 0 || m_pend);
    @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] l, input logic lsb, input logic inv, input logic [2:0] ph);
    cfg_len = l; cfg_lsb_first = lsb; cfg_invert = inv; cfg_phase = ph;
  endtask

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int l = 0; l < 4; l++) begin
      cur_req = (l >= 2) ? "R4" : "R2";
      cfg(2'(l), 1'b0, 1'b0, 3'd1); strobe(10'h2C5); wait_idle();
      cur_req = "R3";
      strobe(10'h3FF); wait_idle();
      strobe(10'h001); wait_idle();
    end

    for (int l = 0; l < 4; l++) begin
      cur_req = "R5";
      cfg(2'(l), 1'b1, 1'b0, 3'd1); strobe(10'h18E); wait_idle();
      cur_req = "R4";
      strobe(10'h3FF); wait_idle();
    end

    cur_req = "R6";
    for (int l = 0; l < 4; l++) begin
      cfg(2'(l), 1'(l % 2), 1'b1, 3'd1); strobe(10'h0F3); wait_idle();
    end

    cur_req = "R7";
    for (int l = 0; l < 4; l++) begin
      cfg(2'(l), 1'b0, 1'b0, 3'd1); strobe(10'h000); wait_idle();
    end

    cur_req = "R8";
    for (int p = 0; p < 8; p++) begin
      cfg(2'd0, 1'b0, 1'b0, 3'(p)); strobe(10'h155); wait_idle();
    end

    cur_req = "R9";
    cfg(2'd3, 1'b0, 1'b0, 3'd2); strobe(10'h2A7);
    repeat (3) @(negedge clk);
    cfg(2'd0, 1'b1, 1'b1, 3'd5);
    wait_idle();

    cur_req = "R10";
    cfg(2'd1, 1'b0, 1'b0, 3'd1);
    strobe(10'h111);
    repeat (2) @(negedge clk);
    strobe(10'h222);
    strobe(10'h333);
    wait_idle();

    cur_req = "R11";
    cfg(2'd0, 1'b1, 1'b0, 3'd4);
    strobe(10'h0AA);
    while (q_bit.size() != 1) @(negedge clk);
    smp_stb = 1'b1; smp_dat = 10'h355;
    @(negedge clk); smp_stb = 1'b0;
    wait_idle();

    cur_req = "R10";
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      smp_stb = ($urandom_range(0, 5) == 0);
      smp_dat = W'($urandom);
      if ($urandom_range(0, 3) == 0)
        cfg(2'($urandom_range(0, 3)), 1'($urandom), 1'($urandom), 3'($urandom_range(0, 7)));
    end
    smp_stb = 1'b0;
    wait_idle();

    cur_req = "R1";
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule